// File: doc/BRIEF.md
# Descriptor list walker for a serial-bus remote terminal

The walker moves through a chain of transfer descriptors kept in memory, handling one descriptor at a time. Each descriptor is three words, 16-byte aligned. The word at offset 0 is control and status. The word at offset 4 is the data buffer address. The word at offset 8 is the address of the next descriptor. The walker reads all three words through a word-wide request/response memory port. It then checks them. If they pass, it gives the buffer address to an external transfer engine and waits for that engine to report completion. After completion it writes a packed status word back to offset 0. It raises a one-cycle log/interrupt request when one is wanted, and then moves to the next descriptor.

The walker stops cleanly in three cases: when it reaches the end-of-list marker, when it finds a malformed or stale descriptor, or when the memory port reports an error. It stays stopped until it is started again with a new list head. The surrounding logic supplies the per-subaddress settings (transfer direction, ignore-valid override, log enable) and a free-running 16-bit terminal timer.

Top module: `dlist_walker`

## Requirements
- R1: Each descriptor is fetched with three single-word reads, in this order: the descriptor address, then +4, then +8. A request keeps its address and direction until the cycle in which the response is returned.
- R2: After a descriptor passes its checks, `xfer_start` pulses for exactly one cycle and `xfer_buf_ptr` carries the fetched buffer address. No write-back is issued before `xfer_done` arrives.
- R3: The write-back word has the following layout. Bit 31 is 1. Bit 30 repeats the fetched override bit. Bits 29:26 are 0. Bits 25:10 hold the `timer` value sampled in the cycle `xfer_done` is seen. Bit 9 is `xfer_bcast`. Bits 8:3 are the word count. Bits 2:0 are the result code. Result codes: 0 ok, 1 cancelled by a newer command on the other bus, 2 memory/DMA fault or timeout, 3 protocol fault, 4 busy or message-error status sent with no data, 5 loopback-checker abort.
- R4: A reported word count above 32 is stored as 32. Counts from 0 to 32 are stored unchanged.
- R5: When the next pointer equals 0x00000003, the walker stops after the write-back completes. `list_done` goes to 1, `busy` drops, and no further memory requests are made.
- R6: For any other valid next pointer, the next descriptor is fetched at exactly that address. Pointer words in memory are never written.
- R7: In receive direction (`is_rx`=1), a fetched bit 31 of 1 raises `err_table`. In that case there is no transfer and no write-back, unless `ign_valid` is 1. In transmit direction, bit 31 is not checked.
- R8: A next pointer whose low four bits are nonzero and which is not 0x00000003 raises `err_table` before any transfer, as does an odd buffer pointer. Nothing is written back for that descriptor.
- R9: `irq_log` pulses for one cycle after a write-back has completed successfully, when fetched bit 30 is 1 or when `sa_log_en` is 1. Otherwise it stays low.
- R10: An error response on any read or write sets `err_mem` and stops the walker. After that there are no more requests or transfers, and no `irq_log` for the faulting descriptor.
- R11: `start` is accepted only while `busy` is 0. When accepted, it clears all flags and begins at `head_ptr`. A `start` pulse while `busy` is 1 has no effect.
- R12: After reset, `busy`, `mem_req`, `xfer_start`, `irq_log`, `list_done`, `err_mem` and `err_table` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin walking at `head_ptr` (accepted when idle) |
| head_ptr | input | 32 | Address of the first descriptor |
| is_rx | input | 1 | Current subaddress direction is receive |
| ign_valid | input | 1 | Skip the stale-valid check |
| sa_log_en | input | 1 | Per-subaddress log/interrupt enable |
| timer | input | 16 | Terminal time counter |
| mem_req | output | 1 | Memory request, held until response |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response for the pending request |
| mem_rsp_err | input | 1 | Response reports a fault |
| mem_rdata | input | 32 | Read data |
| xfer_start | output | 1 | One-cycle launch of a transfer |
| xfer_buf_ptr | output | 32 | Buffer address for the transfer |
| xfer_done | input | 1 | Transfer finished |
| xfer_result | input | 3 | Result code of the finished transfer |
| xfer_words | input | 6 | Words moved |
| xfer_bcast | input | 1 | Transfer was a broadcast |
| irq_log | output | 1 | One-cycle log/interrupt request |
| busy | output | 1 | Walker active |
| list_done | output | 1 | End marker reached |
| err_mem | output | 1 | Stopped on a memory fault |
| err_table | output | 1 | Stopped on a bad descriptor |

## Verification
The bench sweeps every result code, both broadcast values, word counts across the full 6-bit range and several chain layouts. It rebuilds each write-back word arithmetically from the timer value it recorded itself. A clamp that is off by one, or a tag sampled one cycle late, shows up as a wrong status word. The bench places the end marker and the misaligned next pointers so that a walker which follows them would issue extra reads, which the read log records. It injects memory faults into a buffer-address read and into a write-back. A walker that keeps going after a fault, or that still pulses `irq_log` for the failed write, changes the read, write or interrupt counts. It also raises `start` in the middle of a run. A walker that accepts that pulse overwrites the control word of the other descriptor.

// File: rtl/dlw_pkg.sv
package dlw_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned TAG_W    = 16;
    localparam int unsigned SZ_W     = 6;
    localparam int unsigned RES_W    = 3;
    localparam int unsigned RSV_W    = WORD_W - 2 - TAG_W - 1 - SZ_W - RES_W;
    localparam int unsigned BYTES_PW = WORD_W / 8;

    localparam int unsigned BIT_VALID = WORD_W - 1;
    localparam int unsigned BIT_OVR   = WORD_W - 2;

    localparam logic [WORD_W-1:0] LIST_END = 32'h0000_0003;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_CTRL = 3'd1,
        ST_RD_BUF  = 3'd2,
        ST_RD_NEXT = 3'd3,
        ST_CHECK   = 3'd4,
        ST_LAUNCH  = 3'd5,
        ST_WAIT    = 3'd6,
        ST_WRITE   = 3'd7
    } walk_state_e;

    typedef struct packed {
        walk_state_e       state;
        logic [WORD_W-1:0] cur;
        logic              ctrl_valid;
        logic              ctrl_ovr;
        logic [WORD_W-1:0] bufp;
        logic [WORD_W-1:0] nxt;
        logic [WORD_W-1:0] stat;
        logic              irq;
        logic              err_mem;
        logic              err_table;
        logic              done;
    } walk_regs_t;

endpackage

// File: rtl/dlw_ptr_check.sv
module dlw_ptr_check
    import dlw_pkg::*;
#(
    parameter int unsigned NXT_ALIGN_LOG2 = 4,
    parameter int unsigned BUF_ALIGN_LOG2 = 1
) (
    input  logic              valid_bit,
    input  logic [WORD_W-1:0] bufp,
    input  logic [WORD_W-1:0] nxt,
    input  logic              is_rx,
    input  logic              ign_valid,
    output logic              is_end,
    output logic              fault
);
    localparam logic [WORD_W-1:0] NXT_MASK = WORD_W'((64'd1 << NXT_ALIGN_LOG2) - 64'd1);
    localparam logic [WORD_W-1:0] BUF_MASK = WORD_W'((64'd1 << BUF_ALIGN_LOG2) - 64'd1);

    logic nxt_bad;
    logic buf_bad;
    logic stale;

    always_comb begin
        is_end  = (nxt == LIST_END);
        nxt_bad = !is_end && ((nxt & NXT_MASK) != '0);
        buf_bad = ((bufp & BUF_MASK) != '0);
        stale   = is_rx && valid_bit && !ign_valid;
        fault   = nxt_bad || buf_bad || stale;
    end

endmodule

// File: rtl/dlw_stat_pack.sv
module dlw_stat_pack
    import dlw_pkg::*;
#(
    parameter int unsigned MAX_WORDS = 32
) (
    input  logic              ovr,
    input  logic [TAG_W-1:0]  tag,
    input  logic              bcast,
    input  logic [SZ_W-1:0]   words,
    input  logic [RES_W-1:0]  res,
    output logic [WORD_W-1:0] word
);
    localparam int unsigned    SZ_TOP   = (1 << SZ_W) - 1;
    localparam logic [SZ_W-1:0] MAX_CODE = SZ_W'(MAX_WORDS);

    logic [SZ_W-1:0] sz;

    generate
        if (MAX_WORDS >= SZ_TOP) begin : g_noclamp
            assign sz = words;
        end else begin : g_clamp
            assign sz = (words > MAX_CODE) ? MAX_CODE : words;
        end
    endgenerate

    assign word = {1'b1, ovr, {RSV_W{1'b0}}, tag, bcast, sz, res};

endmodule

// File: rtl/dlw_addr_gen.sv
module dlw_addr_gen
    import dlw_pkg::*;
(
    input  walk_state_e       state,
    input  logic [WORD_W-1:0] cur,
    input  logic [WORD_W-1:0] stat,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata
);
    localparam logic [WORD_W-1:0] OFS_BUF = WORD_W'(BYTES_PW);
    localparam logic [WORD_W-1:0] OFS_NXT = WORD_W'(2 * BYTES_PW);

    logic [WORD_W-1:0] ofs;

    always_comb begin
        mem_req = 1'b0;
        mem_we  = 1'b0;
        ofs     = '0;
        case (state)
            ST_RD_CTRL: mem_req = 1'b1;
            ST_RD_BUF: begin
                mem_req = 1'b1;
                ofs     = OFS_BUF;
            end
            ST_RD_NEXT: begin
                mem_req = 1'b1;
                ofs     = OFS_NXT;
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
        mem_addr  = cur + ofs;
        mem_wdata = stat;
    end

endmodule

// File: rtl/dlist_walker.sv
module dlist_walker
    import dlw_pkg::*;
#(
    parameter int unsigned NXT_ALIGN_LOG2 = 4,
    parameter int unsigned BUF_ALIGN_LOG2 = 1,
    parameter int unsigned MAX_WORDS      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] head_ptr,
    input  logic              is_rx,
    input  logic              ign_valid,
    input  logic              sa_log_en,
    input  logic [TAG_W-1:0]  timer,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              xfer_start,
    output logic [WORD_W-1:0] xfer_buf_ptr,
    input  logic              xfer_done,
    input  logic [RES_W-1:0]  xfer_result,
    input  logic [SZ_W-1:0]   xfer_words,
    input  logic              xfer_bcast,
    output logic              irq_log,
    output logic              busy,
    output logic              list_done,
    output logic              err_mem,
    output logic              err_table
);
    walk_regs_t        q;
    walk_regs_t        d;
    logic              nxt_is_end;
    logic              desc_fault;
    logic [WORD_W-1:0] packed_word;

    dlw_ptr_check #(
        .NXT_ALIGN_LOG2(NXT_ALIGN_LOG2),
        .BUF_ALIGN_LOG2(BUF_ALIGN_LOG2)
    ) i_ptr_check (
        .valid_bit (q.ctrl_valid),
        .bufp      (q.bufp),
        .nxt       (q.nxt),
        .is_rx     (is_rx),
        .ign_valid (ign_valid),
        .is_end    (nxt_is_end),
        .fault     (desc_fault)
    );

    dlw_stat_pack #(
        .MAX_WORDS(MAX_WORDS)
    ) i_stat_pack (
        .ovr   (q.ctrl_ovr),
        .tag   (timer),
        .bcast (xfer_bcast),
        .words (xfer_words),
        .res   (xfer_result),
        .word  (packed_word)
    );

    dlw_addr_gen i_addr_gen (
        .state     (q.state),
        .cur       (q.cur),
        .stat      (q.stat),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // Next-state logic: all register updates are computed here.
    always_comb begin
        d     = q;
        d.irq = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.cur       = head_ptr;
                    d.err_mem   = 1'b0;
                    d.err_table = 1'b0;
                    d.done      = 1'b0;
                    d.state     = ST_RD_CTRL;
                end
            end
            ST_RD_CTRL: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        d.err_mem = 1'b1;
                        d.state   = ST_IDLE;
                    end else begin
                        d.ctrl_valid = mem_rdata[BIT_VALID];
                        d.ctrl_ovr   = mem_rdata[BIT_OVR];
                        d.state      = ST_RD_BUF;
                    end
                end
            end
            ST_RD_BUF: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        d.err_mem = 1'b1;
                        d.state   = ST_IDLE;
                    end else begin
                        d.bufp  = mem_rdata;
                        d.state = ST_RD_NEXT;
                    end
                end
            end
            ST_RD_NEXT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        d.err_mem = 1'b1;
                        d.state   = ST_IDLE;
                    end else begin
                        d.nxt   = mem_rdata;
                        d.state = ST_CHECK;
                    end
                end
            end
            ST_CHECK: begin
                if (desc_fault) begin
                    d.err_table = 1'b1;
                    d.state     = ST_IDLE;
                end else begin
                    d.state = ST_LAUNCH;
                end
            end
            ST_LAUNCH: d.state = ST_WAIT;
            ST_WAIT: begin
                if (xfer_done) begin
                    d.stat  = packed_word;
                    d.state = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        d.err_mem = 1'b1;
                        d.state   = ST_IDLE;
                    end else begin
                        d.irq = q.ctrl_ovr || sa_log_en;
                        if (nxt_is_end) begin
                            d.done  = 1'b1;
                            d.state = ST_IDLE;
                        end else begin
                            d.cur   = q.nxt;
                            d.state = ST_RD_CTRL;
                        end
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign xfer_start   = (q.state == ST_LAUNCH);
    assign xfer_buf_ptr = q.bufp;
    assign irq_log      = q.irq;
    assign busy         = (q.state != ST_IDLE);
    assign list_done    = q.done;
    assign err_mem      = q.err_mem;
    assign err_table    = q.err_table;

endmodule

// File: rtl/dlw_checker.sv
module dlw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_rsp_valid,
    input logic        mem_rsp_err,
    input logic        xfer_start,
    input logic [31:0] xfer_buf_ptr,
    input logic        irq_log,
    input logic        busy,
    input logic        list_done,
    input logic        err_mem,
    input logic        err_table
);

    assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rsp_valid |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    assert_word_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    assert_launch_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    assert_wb_fixed_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[31] && (mem_wdata[29:26] == 4'd0));

    assert_size_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[8:3] <= 6'd32);

    assert_end_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        list_done |-> !mem_req && !busy);

    assert_buf_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> !xfer_buf_ptr[0]);

    assert_irq_after_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_log |-> $past(mem_req && mem_we && mem_rsp_valid && !mem_rsp_err));

    assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_log |=> !irq_log);

    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_mem |-> !mem_req && !xfer_start && !busy);

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_mem && err_table));

endmodule

bind dlist_walker dlw_checker i_dlw_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .xfer_start    (xfer_start),
    .xfer_buf_ptr  (xfer_buf_ptr),
    .irq_log       (irq_log),
    .busy          (busy),
    .list_done     (list_done),
    .err_mem       (err_mem),
    .err_table     (err_table)
);

// File: tb/test_dlist_walker.sv
module test_dlist_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] head_ptr = '0;
    logic        is_rx = 1'b0;
    logic        ign_valid = 1'b0;
    logic        sa_log_en = 1'b0;
    logic [15:0] timer = 16'h0100;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        xfer_start;
    logic [31:0] xfer_buf_ptr;
    logic        xfer_done = 1'b0;
    logic [2:0]  xfer_result;
    logic [5:0]  xfer_words;
    logic        xfer_bcast;
    logic        irq_log, busy, list_done, err_mem, err_table;

    always #10 clk = ~clk;

    dlist_walker i_dlist_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .head_ptr(head_ptr),
        .is_rx(is_rx), .ign_valid(ign_valid), .sa_log_en(sa_log_en), .timer(timer),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err), .mem_rdata(mem_rdata),
        .xfer_start(xfer_start), .xfer_buf_ptr(xfer_buf_ptr), .xfer_done(xfer_done),
        .xfer_result(xfer_result), .xfer_words(xfer_words), .xfer_bcast(xfer_bcast),
        .irq_log(irq_log), .busy(busy), .list_done(list_done),
        .err_mem(err_mem), .err_table(err_table)
    );

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;

    logic [31:0] mem [0:63];
    logic [31:0] err_addr = 32'hFFFF_FFF0;
    logic        err_we = 1'b0;
    logic        clr = 1'b0;
    int          rd_cnt = 0, wr_cnt = 0, irq_cnt = 0, xs_cnt = 0, dn_cnt = 0, eng_cnt = 0;
    int          eng_delay = 2;
    logic [31:0] rd_log  [0:63];
    logic [31:0] buf_log [0:15];
    logic [15:0] tag_log [0:15];
    logic [2:0]  plan_res   [0:15];
    logic [5:0]  plan_words [0:15];
    logic        plan_bc    [0:15];

    assign xfer_result = plan_res[dn_cnt % 16];
    assign xfer_words  = plan_words[dn_cnt % 16];
    assign xfer_bcast  = plan_bc[dn_cnt % 16];

    always @(posedge clk) timer <= timer + 16'd37;

    // Memory responder: one-cycle latency, one response per request.
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        mem_rsp_err   <= 1'b0;
        if (clr) begin
            rd_cnt <= 0;
            wr_cnt <= 0;
        end else if (mem_req && !mem_rsp_valid) begin
            mem_rsp_valid <= 1'b1;
            mem_rdata     <= mem[mem_addr[7:2]];
            if (mem_addr == err_addr && mem_we == err_we) mem_rsp_err <= 1'b1;
            else if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
            if (mem_we) wr_cnt <= wr_cnt + 1;
            else begin
                if (rd_cnt < 64) rd_log[rd_cnt] <= mem_addr;
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    // Transfer engine and interrupt counter.
    always @(posedge clk) begin
        xfer_done <= 1'b0;
        if (clr) begin
            irq_cnt <= 0;
            xs_cnt  <= 0;
            dn_cnt  <= 0;
            eng_cnt <= 0;
        end else begin
            if (irq_log) irq_cnt <= irq_cnt + 1;
            if (xfer_start) begin
                buf_log[xs_cnt % 16] <= xfer_buf_ptr;
                xs_cnt  <= xs_cnt + 1;
                eng_cnt <= eng_delay;
            end else if (eng_cnt != 0) begin
                eng_cnt <= eng_cnt - 1;
                if (eng_cnt == 1) xfer_done <= 1'b1;
            end
            if (xfer_done) begin
                tag_log[dn_cnt % 16] <= timer;
                dn_cnt <= dn_cnt + 1;
            end
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat(logic ovr, logic [15:0] tag, logic bc,
                                             logic [5:0] w, logic [2:0] r);
        logic [5:0] sz;
        sz = (w > 6'd32) ? 6'd32 : w;
        return {1'b1, ovr, 4'b0000, tag, bc, sz, r};
    endfunction

    task automatic put_desc(int slot, logic [31:0] ctrl, logic [31:0] bufp, logic [31:0] nxt);
        mem[slot*4]     <= ctrl;
        mem[slot*4 + 1] <= bufp;
        mem[slot*4 + 2] <= nxt;
    endtask

    task automatic wait_idle();
        int k;
        k = 0;
        while (busy && k < 4000) begin
            @(negedge clk);
            k++;
        end
        if (busy) chk("R5", "walker never went idle", 32'd1, 32'd0);
        repeat (3) @(negedge clk);
    endtask

    task automatic run(logic [31:0] head);
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        start = 1'b1;
        head_ptr = head;
        @(negedge clk) start = 1'b0;
        wait_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL R5 watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] <= '0;
        for (int i = 0; i < 16; i++) begin
            plan_res[i] = '0; plan_words[i] = '0; plan_bc[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "busy", busy, 0);
        chk("R12", "mem_req", mem_req, 0);
        chk("R12", "xfer_start", xfer_start, 0);
        chk("R12", "irq_log", irq_log, 0);
        chk("R12", "flags", {list_done, err_mem, err_table}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R12", "idle after release", {busy, mem_req}, 0);

        // Sweep: result codes x broadcast, three-descriptor chains
        for (int r = 0; r < 6; r++) begin
            for (int b = 0; b < 2; b++) begin
                int          sl [3];
                logic        ov [3];
                logic [31:0] bp [3];
                int          exp_irq;
                sl[0] = 1 + ((r + b) % 4);
                sl[1] = 6 + ((r * 3 + b) % 4);
                sl[2] = 11 + ((r + 2 * b) % 4);
                exp_irq = 0;
                is_rx = b[0];
                ign_valid = 1'b0;
                sa_log_en = (r % 3 == 0);
                eng_delay = 1 + r;
                for (int i = 0; i < 3; i++) begin
                    plan_res[i]   = 3'((r + i) % 6);
                    plan_words[i] = 6'((r * 11 + b * 29 + i * 23) % 64);
                    plan_bc[i]    = ((r + b + i) % 2) == 1;
                    ov[i]         = (i == (r % 3));
                    bp[i]         = 32'h1000 + 32'(r * 64 + b * 16 + i * 2);
                    if (ov[i] || sa_log_en) exp_irq++;
                    put_desc(sl[i], {1'b0, ov[i], 30'h2AAA_5555}, bp[i],
                             (i == 2) ? 32'h3 : 32'(sl[i+1] * 16));
                end
                run(32'(sl[0] * 16));
                for (int i = 0; i < 3; i++) begin
                    chk((plan_words[i] > 6'd32) ? "R4" : "R3", "status word", mem[sl[i]*4],
                        exp_stat(ov[i], tag_log[i], plan_bc[i], plan_words[i], plan_res[i]));
                    chk("R6", "next pointer kept", mem[sl[i]*4 + 2],
                        (i == 2) ? 32'h3 : 32'(sl[i+1] * 16));
                    chk("R2", "buffer handed over", buf_log[i], bp[i]);
                    for (int k = 0; k < 3; k++)
                        chk("R1", "read address", rd_log[i*3 + k], 32'(sl[i] * 16 + k * 4));
                end
                chk("R5", "read count", rd_cnt, 9);
                chk("R5", "write count", wr_cnt, 3);
                chk("R5", "done/busy", {list_done, busy}, 2'b10);
                chk("R9", "irq count", irq_cnt, exp_irq);
                chk("R10", "no error flags", {err_mem, err_table}, 0);
            end
        end

        // R7: stale valid bit in receive direction
        for (int i = 0; i < 16; i++) begin
            plan_res[i] = 3'd0; plan_words[i] = 6'd4; plan_bc[i] = 1'b0;
        end
        sa_log_en = 1'b0;
        eng_delay = 2;
        is_rx = 1'b1; ign_valid = 1'b0;
        put_desc(2, 32'h8000_0123, 32'h2000, 32'h3);
        run(32'h20);
        chk("R7", "table error", {err_table, err_mem, list_done}, 3'b100);
        chk("R7", "no transfer", xs_cnt, 0);
        chk("R7", "no write-back", wr_cnt, 0);
        chk("R7", "word untouched", mem[8], 32'h8000_0123);

        ign_valid = 1'b1;
        run(32'h20);
        chk("R7", "override proceeds", {err_table, list_done}, 2'b01);
        chk("R7", "override status", mem[8], exp_stat(1'b0, tag_log[0], 1'b0, 6'd4, 3'd0));

        is_rx = 1'b0; ign_valid = 1'b0;
        put_desc(2, 32'h8000_0000, 32'h2002, 32'h3);
        run(32'h20);
        chk("R7", "transmit ignores bit 31", {err_table, list_done, 6'(wr_cnt)}, {2'b01, 6'd1});

        // R8: pointer alignment
        put_desc(5, 32'h0, 32'h2000, 32'h58);
        run(32'h50);
        chk("R8", "misaligned next", {err_table, 6'(xs_cnt), 6'(wr_cnt)}, {1'b1, 12'd0});
        put_desc(5, 32'h0, 32'h2000, 32'h13);
        run(32'h50);
        chk("R8", "next low bits 3", {err_table, 6'(xs_cnt)}, {1'b1, 6'd0});
        put_desc(5, 32'h0, 32'h2001, 32'h3);
        run(32'h50);
        chk("R8", "odd buffer", {err_table, 6'(xs_cnt), 6'(wr_cnt)}, {1'b1, 12'd0});
        chk("R8", "word untouched", mem[20], 32'h0);
        put_desc(1, 32'h0, 32'h2000, 32'h30);
        put_desc(3, 32'h0, 32'h2004, 32'h34);
        run(32'h10);
        chk("R8", "second descriptor rejected", {err_table, 6'(xs_cnt), 6'(wr_cnt), 6'(rd_cnt)},
            {1'b1, 6'd1, 6'd1, 6'd6});
        chk("R8", "second word untouched", mem[12], 32'h0);

        // R10: memory faults
        put_desc(1, 32'h4000_0000, 32'h2000, 32'h20);
        put_desc(2, 32'h0, 32'h2010, 32'h3);
        err_addr = 32'h24; err_we = 1'b0;
        run(32'h10);
        chk("R10", "read fault flag", {err_mem, err_table, list_done}, 3'b100);
        chk("R10", "read fault counts", {6'(rd_cnt), 6'(wr_cnt), 6'(xs_cnt), 6'(irq_cnt)},
            {6'd5, 6'd1, 6'd1, 6'd1});
        put_desc(1, 32'h4000_0000, 32'h2000, 32'h20);
        err_addr = 32'h10; err_we = 1'b1;
        run(32'h10);
        chk("R10", "write fault flag", {err_mem, busy}, 2'b10);
        chk("R10", "write fault counts", {6'(rd_cnt), 6'(wr_cnt), 6'(irq_cnt)},
            {6'd3, 6'd1, 6'd0});
        chk("R10", "faulted word untouched", mem[4], 32'h4000_0000);
        err_addr = 32'hFFFF_FFF0;

        // R11: restart clears flags; start while busy ignored
        put_desc(1, 32'h0, 32'h2000, 32'h3);
        run(32'h10);
        chk("R11", "restart clears error", {err_mem, err_table, list_done}, 3'b001);
        put_desc(3, 32'h0, 32'h2008, 32'h3);
        put_desc(9, 32'h0000_0ABC, 32'h2010, 32'h3);
        eng_delay = 40;
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        start = 1'b1; head_ptr = 32'h30;
        @(negedge clk) start = 1'b0;
        repeat (10) @(negedge clk);
        start = 1'b1; head_ptr = 32'h90;
        @(negedge clk) start = 1'b0;
        wait_idle();
        chk("R11", "other list untouched", mem[36], 32'h0000_0ABC);
        chk("R11", "single walk", {6'(rd_cnt), 6'(wr_cnt)}, {6'd3, 6'd1});
        chk("R11", "first list written", mem[12], exp_stat(1'b0, tag_log[0], 1'b0, 6'd4, 3'd0));

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule